// File: doc/BRIEF.md
# Circular Trace Capture Buffer

The block records a stream of trace words into an on-chip circular RAM while capture is switched on. A write pointer walks the RAM and wraps at its end. A sticky flag marks the first wrap, so software knows the oldest entry sits at the write pointer. Once a trigger pulse arrives, a programmable post-trigger count sets how many more RAM writes happen before capture halts by itself. This count fixes how much of the buffer holds history after the event and how much holds history before it.

Two capture formats exist. In the wide format every valid trace word fills one RAM entry. In the packed format the low halves of two consecutive valid trace words share one entry. A half that is still waiting for its partner is reported as undrained data, and it is pushed out when capture stops. Software uses a small register port to arm a run, to poll four status bits, to set either pointer, and to drain the RAM through a data port that advances the read pointer on every read.

Top module: `trace_capture_buf`

## Requirements
- R1: After reset, status_o is 4'b1000 and the control, read pointer, write pointer and post-trigger count registers all read as zero.
- R2: Control bit 0 (address 0) enables capture. Each cycle with enable set and trace_vld_i high stores one entry (wide format) at the write pointer, and the pointer then steps modulo DEPTH. Trace words offered while capture is disabled leave the write pointer unchanged.
- R3: With control bit 1 set, a whole TRACE_W-bit word is stored per valid cycle. With bit 1 clear, the low halves of two consecutive valid words form one entry, the first half in the low half of the entry. Status bit 3 is 0 while a lone half is waiting.
- R4: When capture is disabled while a half is waiting, that half is written at the write pointer one cycle later with a zero upper half. Status bit 3 then returns to 1.
- R5: Status bit 0 becomes 1 when a RAM write lands on entry DEPTH-1, and it stays 1 until the next run start.
- R6: Status bit 1 becomes 1 on a trig_i pulse while capture is enabled. A pulse while capture is disabled has no effect.
- R7: The post-trigger count (address 7) drops by one on each capture write made while status bit 1 was already set. The write that finds the count at 1 or 0 sets status bit 2 and clears control bit 0, and later trace words are not stored.
- R8: A read of address 4 returns the entry at the read pointer and steps the read pointer modulo DEPTH. Every read returns its data with reg_rvalid_o exactly one cycle after reg_re_i.
- R9: The read pointer (address 5), write pointer (address 6) and post-trigger count (address 7) read back what was written. Writing control bit 0 as 1 while capture is off starts a run and clears status bits 0, 1 and 2.
- R10: Address 2 reports DEPTH and address 3 reports TRACE_W. Writes to these addresses have no effect. Address 1 returns status_o in bits 3:0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| trace_i | input | TRACE_W | Trace word |
| trace_vld_i | input | 1 | Trace word valid |
| trig_i | input | 1 | Trigger event pulse |
| reg_we_i | input | 1 | Register write strobe |
| reg_re_i | input | 1 | Register read strobe |
| reg_addr_i | input | 4 | Register address |
| reg_wdata_i | input | 32 | Register write data |
| reg_rdata_o | output | 32 | Register read data, valid with reg_rvalid_o |
| reg_rvalid_o | output | 1 | Read data valid, one cycle after reg_re_i |
| status_o | output | 4 | {undrained-empty, acquisition done, triggered, wrapped} |

## Verification
Short bursts in the wide format with idle gaps show that only enabled valid cycles move the write pointer. A burst longer than the RAM shows the wrap flag and the oldest-first read order from the write pointer. Trigger runs separate the trigger-cycle write, which is not counted, from the counted writes that follow, and compare a preset count against a count of zero. A trigger pulse while capture is off shows that it is ignored. An odd number of samples in the packed format exposes the pairing order, the pending flag and the flush on stop.

// File: rtl/tcb_pkg.sv
package tcb_pkg;

  localparam int unsigned BusW  = 32;
  localparam int unsigned RegAW = 4;

  typedef enum logic [RegAW-1:0] {
    A_CTRL  = 4'd0,
    A_STAT  = 4'd1,
    A_DEPTH = 4'd2,
    A_WIDTH = 4'd3,
    A_DATA  = 4'd4,
    A_RPTR  = 4'd5,
    A_WPTR  = 4'd6,
    A_TCNT  = 4'd7
  } reg_addr_e;

  // bit 0 = wrapped ... bit 3 = nothing pending
  typedef struct packed {
    logic drained;
    logic acq_done;
    logic triggered;
    logic wrapped;
  } stat_t;

  typedef struct packed {
    logic wide;
    logic enable;
  } ctrl_t;

endpackage

// File: rtl/tcb_ram.sv
module tcb_ram #(
  parameter int unsigned DEPTH = 16,
  parameter int unsigned WIDTH = 16,
  localparam int unsigned AW = $clog2(DEPTH)
) (
  input  logic             clk_i,
  input  logic             we_i,
  input  logic [AW-1:0]    waddr_i,
  input  logic [WIDTH-1:0] wdata_i,
  input  logic             re_i,
  input  logic [AW-1:0]    raddr_i,
  output logic [WIDTH-1:0] rdata_o
);

  logic [WIDTH-1:0] mem_q [DEPTH];
  logic [WIDTH-1:0] q_q;

  always_ff @(posedge clk_i) begin
    if (we_i) mem_q[waddr_i] <= wdata_i;
    if (re_i) q_q <= mem_q[raddr_i];
  end

  assign rdata_o = q_q;

endmodule

// File: rtl/tcb_capture.sv
module tcb_capture
  import tcb_pkg::*;
#(
  parameter int unsigned DEPTH   = 16,
  parameter int unsigned TRACE_W = 16,
  localparam int unsigned AW = $clog2(DEPTH),
  localparam int unsigned CW = AW + 1
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [TRACE_W-1:0] trace_i,
  input  logic               trace_vld_i,
  input  logic               trig_i,
  input  logic               ctrl_we_i,
  input  ctrl_t              ctrl_wdata_i,
  input  logic               wp_we_i,
  input  logic [AW-1:0]      wp_wdata_i,
  input  logic               cnt_we_i,
  input  logic [CW-1:0]      cnt_wdata_i,
  output ctrl_t              ctrl_o,
  output logic [AW-1:0]      wp_o,
  output logic [CW-1:0]      cnt_o,
  output stat_t              stat_o,
  output logic               ram_we_o,
  output logic [AW-1:0]      ram_waddr_o,
  output logic [TRACE_W-1:0] ram_wdata_o
);

  localparam int unsigned HW = TRACE_W / 2;

  function automatic logic [AW-1:0] ptr_next(input logic [AW-1:0] p);
    if (p == AW'(DEPTH - 1)) return '0;
    return p + 1'b1;
  endfunction

  function automatic logic [TRACE_W-1:0] pack_pair(input logic [HW-1:0] hi,
                                                  input logic [HW-1:0] lo);
    logic [TRACE_W-1:0] w;
    w = '0;
    w[HW-1:0]      = lo;
    w[2*HW-1:HW]   = hi;
    return w;
  endfunction

  ctrl_t          ctrl_q;
  logic [AW-1:0]  wp_q;
  logic [CW-1:0]  cnt_q;
  logic           pend_q;
  logic [HW-1:0]  hold_q;
  logic           wrapped_q, trig_q, acq_q;

  // named internal events
  logic accept_evt, cap_wr_evt, flush_evt, count_evt, acq_evt, start_evt;
  logic trig_evt, wrap_evt, ram_we;
  logic [TRACE_W-1:0] wr_word;

  assign accept_evt = ctrl_q.enable && trace_vld_i;
  assign cap_wr_evt = accept_evt && (ctrl_q.wide || pend_q);
  assign flush_evt  = !ctrl_q.enable && pend_q;
  assign ram_we     = cap_wr_evt || flush_evt;
  assign count_evt  = cap_wr_evt && trig_q;
  assign acq_evt    = count_evt && (cnt_q <= CW'(1));
  assign start_evt  = ctrl_we_i && ctrl_wdata_i.enable && !ctrl_q.enable;
  assign trig_evt   = trig_i && ctrl_q.enable;
  assign wrap_evt   = ram_we && (wp_q == AW'(DEPTH - 1));

  always_comb begin
    if (flush_evt)        wr_word = pack_pair('0, hold_q);
    else if (ctrl_q.wide) wr_word = trace_i;
    else                  wr_word = pack_pair(trace_i[HW-1:0], hold_q);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_q <= '0;
    end else if (ctrl_we_i) begin
      ctrl_q <= ctrl_wdata_i;
    end else if (acq_evt) begin
      ctrl_q.enable <= 1'b0;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pend_q <= 1'b0;
      hold_q <= '0;
    end else if (accept_evt && !ctrl_q.wide) begin
      if (pend_q) begin
        pend_q <= 1'b0;
      end else begin
        pend_q <= 1'b1;
        hold_q <= trace_i[HW-1:0];
      end
    end else if (flush_evt) begin
      pend_q <= 1'b0;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      wp_q <= '0;
    else if (wp_we_i) wp_q <= wp_wdata_i;
    else if (ram_we)  wp_q <= ptr_next(wp_q);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                          cnt_q <= '0;
    else if (cnt_we_i)                    cnt_q <= cnt_wdata_i;
    else if (count_evt && cnt_q != '0)    cnt_q <= cnt_q - 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wrapped_q <= 1'b0;
      trig_q    <= 1'b0;
      acq_q     <= 1'b0;
    end else if (start_evt) begin
      wrapped_q <= 1'b0;
      trig_q    <= 1'b0;
      acq_q     <= 1'b0;
    end else begin
      if (wrap_evt) wrapped_q <= 1'b1;
      if (trig_evt) trig_q    <= 1'b1;
      if (acq_evt)  acq_q     <= 1'b1;
    end
  end

  assign ctrl_o      = ctrl_q;
  assign wp_o        = wp_q;
  assign cnt_o       = cnt_q;
  assign stat_o      = '{drained: !pend_q, acq_done: acq_q,
                         triggered: trig_q, wrapped: wrapped_q};
  assign ram_we_o    = ram_we;
  assign ram_waddr_o = wp_q;
  assign ram_wdata_o = wr_word;

  AST_WP_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ram_we && !wp_we_i) |=> (wp_q == ptr_next($past(wp_q)))); // R2
  AST_IDLE_NO_WRITE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!ctrl_q.enable && !pend_q) |-> !ram_we_o); // R2
  AST_FLUSH_DONE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!ctrl_q.enable && pend_q && !ctrl_we_i) |=> stat_o.drained); // R4
  AST_WRAP_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wrapped_q && !start_evt) |=> wrapped_q); // R5
  AST_ACQ_HALTS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    acq_q |-> !ctrl_q.enable); // R7
  AST_ACQ_AFTER_TRIG: assert property (@(posedge clk_i) disable iff (!rst_ni)
    acq_q |-> trig_q); // R7
  AST_TRIG_OFF_IGNORED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!trig_q && !ctrl_q.enable && !ctrl_we_i) |=> !trig_q); // R6

endmodule

// File: rtl/tcb_regs.sv
module tcb_regs
  import tcb_pkg::*;
#(
  parameter int unsigned DEPTH   = 16,
  parameter int unsigned TRACE_W = 16,
  localparam int unsigned AW = $clog2(DEPTH),
  localparam int unsigned CW = AW + 1
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               reg_we_i,
  input  logic               reg_re_i,
  input  logic [RegAW-1:0]   reg_addr_i,
  input  logic [BusW-1:0]    reg_wdata_i,
  input  ctrl_t              ctrl_i,
  input  stat_t              stat_i,
  input  logic [AW-1:0]      wp_i,
  input  logic [CW-1:0]      cnt_i,
  input  logic [TRACE_W-1:0] ram_q_i,
  output logic               ctrl_we_o,
  output ctrl_t              ctrl_wdata_o,
  output logic               wp_we_o,
  output logic [AW-1:0]      wp_wdata_o,
  output logic               cnt_we_o,
  output logic [CW-1:0]      cnt_wdata_o,
  output logic               ram_re_o,
  output logic [AW-1:0]      ram_raddr_o,
  output logic [BusW-1:0]    rdata_o,
  output logic               rvalid_o
);

  function automatic logic [AW-1:0] ptr_next(input logic [AW-1:0] p);
    if (p == AW'(DEPTH - 1)) return '0;
    return p + 1'b1;
  endfunction

  logic [AW-1:0]   rp_q;
  logic [BusW-1:0] snap_q, reg_val;
  logic            sel_ram_q, rvalid_q;
  logic            rp_we, data_rd;

  assign ctrl_we_o    = reg_we_i && (reg_addr_i == A_CTRL);
  assign wp_we_o      = reg_we_i && (reg_addr_i == A_WPTR);
  assign cnt_we_o     = reg_we_i && (reg_addr_i == A_TCNT);
  assign rp_we        = reg_we_i && (reg_addr_i == A_RPTR);
  assign ctrl_wdata_o = reg_wdata_i[1:0];
  assign wp_wdata_o   = reg_wdata_i[AW-1:0];
  assign cnt_wdata_o  = reg_wdata_i[CW-1:0];
  assign data_rd      = reg_re_i && (reg_addr_i == A_DATA);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      rp_q <= '0;
    else if (rp_we)   rp_q <= reg_wdata_i[AW-1:0];
    else if (data_rd) rp_q <= ptr_next(rp_q);
  end

  always_comb begin
    unique case (reg_addr_i)
      A_CTRL:  reg_val = BusW'(ctrl_i);
      A_STAT:  reg_val = BusW'(stat_i);
      A_DEPTH: reg_val = BusW'(DEPTH);
      A_WIDTH: reg_val = BusW'(TRACE_W);
      A_RPTR:  reg_val = BusW'(rp_q);
      A_WPTR:  reg_val = BusW'(wp_i);
      A_TCNT:  reg_val = BusW'(cnt_i);
      default: reg_val = '0;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      snap_q    <= '0;
      sel_ram_q <= 1'b0;
      rvalid_q  <= 1'b0;
    end else begin
      rvalid_q <= reg_re_i;
      if (reg_re_i) begin
        snap_q    <= reg_val;
        sel_ram_q <= data_rd;
      end
    end
  end

  assign ram_re_o    = data_rd;
  assign ram_raddr_o = rp_q;
  assign rdata_o     = sel_ram_q ? BusW'(ram_q_i) : snap_q;
  assign rvalid_o    = rvalid_q;

  AST_RP_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (data_rd && !rp_we) |=> (rp_q == ptr_next($past(rp_q)))); // R8
  AST_RVALID_LAT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    reg_re_i |=> rvalid_o); // R8
  AST_RVALID_ONLY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !reg_re_i |=> !rvalid_o); // R8

endmodule

// File: rtl/trace_capture_buf.sv
module trace_capture_buf
  import tcb_pkg::*;
#(
  parameter int unsigned DEPTH   = 16,
  parameter int unsigned TRACE_W = 16
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [TRACE_W-1:0] trace_i,
  input  logic               trace_vld_i,
  input  logic               trig_i,
  input  logic               reg_we_i,
  input  logic               reg_re_i,
  input  logic [3:0]         reg_addr_i,
  input  logic [31:0]        reg_wdata_i,
  output logic [31:0]        reg_rdata_o,
  output logic               reg_rvalid_o,
  output logic [3:0]         status_o
);

  localparam int unsigned AW = $clog2(DEPTH);
  localparam int unsigned CW = AW + 1;

  ctrl_t              ctrl, ctrl_wdata;
  stat_t              stat;
  logic               ctrl_we, wp_we, cnt_we, ram_we, ram_re;
  logic [AW-1:0]      wp, wp_wdata, ram_waddr, ram_raddr;
  logic [CW-1:0]      cnt, cnt_wdata;
  logic [TRACE_W-1:0] ram_wdata, ram_q;

  tcb_capture #(.DEPTH(DEPTH), .TRACE_W(TRACE_W)) u_cap (
    .clk_i, .rst_ni, .trace_i, .trace_vld_i, .trig_i,
    .ctrl_we_i(ctrl_we), .ctrl_wdata_i(ctrl_wdata),
    .wp_we_i(wp_we), .wp_wdata_i(wp_wdata),
    .cnt_we_i(cnt_we), .cnt_wdata_i(cnt_wdata),
    .ctrl_o(ctrl), .wp_o(wp), .cnt_o(cnt), .stat_o(stat),
    .ram_we_o(ram_we), .ram_waddr_o(ram_waddr), .ram_wdata_o(ram_wdata)
  );

  tcb_regs #(.DEPTH(DEPTH), .TRACE_W(TRACE_W)) u_regs (
    .clk_i, .rst_ni, .reg_we_i, .reg_re_i, .reg_addr_i, .reg_wdata_i,
    .ctrl_i(ctrl), .stat_i(stat), .wp_i(wp), .cnt_i(cnt), .ram_q_i(ram_q),
    .ctrl_we_o(ctrl_we), .ctrl_wdata_o(ctrl_wdata),
    .wp_we_o(wp_we), .wp_wdata_o(wp_wdata),
    .cnt_we_o(cnt_we), .cnt_wdata_o(cnt_wdata),
    .ram_re_o(ram_re), .ram_raddr_o(ram_raddr),
    .rdata_o(reg_rdata_o), .rvalid_o(reg_rvalid_o)
  );

  tcb_ram #(.DEPTH(DEPTH), .WIDTH(TRACE_W)) u_ram (
    .clk_i, .we_i(ram_we), .waddr_i(ram_waddr), .wdata_i(ram_wdata),
    .re_i(ram_re), .raddr_i(ram_raddr), .rdata_o(ram_q)
  );

  assign status_o = stat;

  AST_RESET_STATUS: assert property (@(posedge clk_i)
    $rose(rst_ni) |-> (status_o == 4'b1000)); // R1

endmodule

// File: tb/trace_capture_buf_tb_top.sv
`timescale 1ns/1ps
module trace_capture_buf_tb_top;

  localparam int DEPTH = 16;
  localparam int TW    = 16;
  localparam int HW    = TW / 2;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [TW-1:0] trace = '0;
  logic          tvld = 1'b0, trig = 1'b0;
  logic          we = 1'b0, re = 1'b0;
  logic [3:0]    addr = '0;
  logic [31:0]   wdata = '0;
  logic [31:0]   rdata;
  logic          rvalid;
  logic [3:0]    status;

  int tests = 0;
  int fails = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  trace_capture_buf #(.DEPTH(DEPTH), .TRACE_W(TW)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .trace_i(trace), .trace_vld_i(tvld),
    .trig_i(trig), .reg_we_i(we), .reg_re_i(re), .reg_addr_i(addr),
    .reg_wdata_i(wdata), .reg_rdata_o(rdata), .reg_rvalid_o(rvalid),
    .status_o(status)
  );

  // behavioural reference for the status flags
  bit m_en, m_wide, m_pend, m_full, m_trig, m_acq;
  int m_wp, m_cnt;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_en = 0; m_wide = 0; m_pend = 0; m_full = 0; m_trig = 0; m_acq = 0;
      m_wp = 0; m_cnt = 0;
    end else begin
      bit acc, wr_cap, fl, wr, counted, stop, start;
      acc     = m_en && tvld;
      wr_cap  = acc && (m_wide || m_pend);
      fl      = !m_en && m_pend;
      wr      = wr_cap || fl;
      counted = wr_cap && m_trig;
      stop    = counted && (m_cnt <= 1);
      start   = we && addr == 0 && wdata[0] && !m_en;
      if (start) begin
        m_full = 0; m_trig = 0; m_acq = 0;
      end else begin
        if (wr && m_wp == DEPTH - 1) m_full = 1;
        if (trig && m_en) m_trig = 1;
        if (stop) m_acq = 1;
      end
      if (acc && !m_wide) m_pend = !m_pend;
      else if (fl) m_pend = 0;
      if (we && addr == 6) m_wp = int'(wdata) % DEPTH;
      else if (wr) m_wp = (m_wp + 1) % DEPTH;
      if (we && addr == 7) m_cnt = int'(wdata) % (2 * DEPTH);
      else if (counted && m_cnt > 0) m_cnt = m_cnt - 1;
      if (we && addr == 0) begin
        m_en = wdata[0]; m_wide = wdata[1];
      end else if (stop) m_en = 0;
    end
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // every-clock comparison against the reference (R3 R5 R6 R7)
  always @(negedge clk) begin
    if (rst_n && !done)
      chk("R3 R5 R6 R7 status vs model", {28'b0, status},
          {28'b0, !m_pend, m_acq, m_trig, m_full});
  end

  task automatic tick();
    @(posedge clk); @(negedge clk);
  endtask

  task automatic reg_wr(input logic [3:0] a, input logic [31:0] d);
    we = 1; addr = a; wdata = d;
    tick();
    we = 0;
  endtask

  task automatic reg_rd(input logic [3:0] a, output logic [31:0] d);
    re = 1; addr = a;
    tick();
    re = 0;
    chk("R8 rvalid one cycle after request", {31'b0, rvalid}, 32'd1);
    d = rdata;
  endtask

  task automatic rd_chk(input string tag, input logic [3:0] a, input logic [31:0] exp);
    logic [31:0] d;
    reg_rd(a, d);
    chk(tag, d, exp);
  endtask

  task automatic push(input logic [TW-1:0] w, input bit t);
    tvld = 1; trace = w; trig = t;
    tick();
    tvld = 0; trig = 0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1 reset state
    chk("R1 status after reset", {28'b0, status}, 32'h8);
    rd_chk("R1 ctrl reset", 4'd0, 0);
    rd_chk("R1 rptr reset", 4'd5, 0);
    rd_chk("R1 wptr reset", 4'd6, 0);
    rd_chk("R1 tcnt reset", 4'd7, 0);
    // R10 geometry registers
    rd_chk("R10 depth", 4'd2, DEPTH);
    rd_chk("R10 width", 4'd3, TW);
    reg_wr(4'd2, 32'd99);
    reg_wr(4'd3, 32'd7);
    rd_chk("R10 depth after write", 4'd2, DEPTH);
    rd_chk("R10 width after write", 4'd3, TW);
    rd_chk("R10 status register", 4'd1, 32'h8);
    // R9 pointer and count readback
    reg_wr(4'd5, 3); reg_wr(4'd6, 2); reg_wr(4'd7, 5);
    rd_chk("R9 rptr readback", 4'd5, 3);
    rd_chk("R9 wptr readback", 4'd6, 2);
    rd_chk("R9 tcnt readback", 4'd7, 5);

    // R2 R3 wide format short burst with gaps
    reg_wr(4'd6, 0); reg_wr(4'd7, 8); reg_wr(4'd0, 3);
    for (int i = 0; i < 5; i++) begin
      push(16'hA000 + 16'(i), 0);
      tick();
    end
    reg_wr(4'd0, 0);
    rd_chk("R2 wptr after 5 words", 4'd6, 5);
    push(16'hEEEE, 0);
    rd_chk("R2 disabled word ignored", 4'd6, 5);
    reg_wr(4'd5, 0);
    for (int i = 0; i < 5; i++)
      rd_chk("R3 R8 wide readback", 4'd4, 32'hA000 + i);
    rd_chk("R8 rptr advanced", 4'd5, 5);

    // R5 wrap
    reg_wr(4'd6, 0); reg_wr(4'd0, 3);
    for (int i = 0; i < 18; i++) push(16'hB000 + 16'(i), 0);
    chk("R5 wrapped flag", {31'b0, status[0]}, 1);
    reg_wr(4'd0, 0);
    rd_chk("R5 wptr after wrap", 4'd6, 2);
    reg_wr(4'd5, 2);
    for (int i = 0; i < 16; i++)
      rd_chk("R5 R8 oldest-first order", 4'd4, 32'hB002 + i);
    reg_wr(4'd5, 15);
    rd_chk("R8 last entry", 4'd4, 32'hB00F);
    rd_chk("R8 read pointer wraps", 4'd4, 32'hB010);

    // R6 trigger while disabled
    trig = 1; tick(); trig = 0;
    chk("R6 trigger ignored while off", {31'b0, status[1]}, 0);

    // R7 R9 trigger run with count 3
    reg_wr(4'd6, 0); reg_wr(4'd7, 3); reg_wr(4'd0, 3);
    chk("R9 start clears flags", {28'b0, status}, 32'h8);
    push(16'hC000, 0); push(16'hC001, 0);
    push(16'hC002, 1);
    chk("R6 triggered set", {31'b0, status[1]}, 1);
    push(16'hC003, 0); push(16'hC004, 0);
    chk("R7 not done before count", {31'b0, status[2]}, 0);
    push(16'hC005, 0);
    chk("R7 done after count", {28'b0, status}, 32'hE);
    rd_chk("R7 enable cleared", 4'd0, 2);
    push(16'hC006, 0); push(16'hC007, 0);
    rd_chk("R7 later words not stored", 4'd6, 6);
    rd_chk("R7 count reached zero", 4'd7, 0);

    // R7 count zero
    reg_wr(4'd6, 0); reg_wr(4'd7, 0); reg_wr(4'd0, 3);
    trig = 1; tick(); trig = 0;
    push(16'hD000, 0);
    chk("R7 zero count stops at first write", {28'b0, status}, 32'hE);
    rd_chk("R7 one word after zero count", 4'd6, 1);

    // R3 R4 packed format
    reg_wr(4'd6, 0); reg_wr(4'd0, 1);
    push(16'h1111, 0); push(16'h2222, 0); push(16'h3333, 0);
    chk("R3 half pending", {31'b0, status[3]}, 0);
    reg_wr(4'd0, 0);
    tick();
    chk("R4 flushed", {31'b0, status[3]}, 1);
    rd_chk("R4 wptr after flush", 4'd6, 2);
    reg_wr(4'd5, 0);
    rd_chk("R3 packed pair order", 4'd4, 32'h2211);
    rd_chk("R4 flushed half zero-extended", 4'd4, 32'h0033);

    tick();
    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule